// File: doc/BRIEF.md
# Banked Expansion-Memory Slot Decoder

This block is the decode and bank-switching logic of a peripheral card on an 8-bit expansion slot. The card carries a 512 kB non-volatile memory and a small SRAM write buffer. The non-volatile memory is divided into 256 banks of 2 kB. Any one bank can be shown in the shared 2 kB expansion window at $C800-$CFFF. The top 256 bytes of the memory are always visible in the card's private 256-byte slot page.

Software writes a bank number to the card's I/O location. That write loads the bank register and arms the window. A write to the last byte of the window, $CFFF, disarms it again, so the card stops claiming the shared range. A mode input lets the window serve both memories at once, in opposite directions. When the mode is 1, writes go to the SRAM buffer and reads come from the non-volatile memory. When the mode is 0, the roles swap.

Regions are qualified by the slot's active-low select strobes. The bank register and the armed flag change on the falling edge of the phase-2 clock, at the end of the bus cycle. All other outputs are combinational.

Top module: `slot_bank_decoder`

## Requirements
- R1: After reset the bank is 0x00 and the window is disarmed. A window access (io_strobe_n low, io_sel_n high) then asserts neither chip enable, keeps oe_n and we_n high and bus_drive low, and mem_addr reads {0x00, addr[10:0]}.
- R2: A write cycle with dev_sel_n low loads din into the bank register at the end of that cycle.
- R3: That same write arms the window from the next cycle on.
- R4: A window write to offset 0x7FF ($CFFF), with dev_sel_n high, still reaches its memory in that cycle. From the next cycle on, the window is disarmed.
- R5: A slot-page access (io_sel_n low) uses mem_addr = 0x7FF00 + addr[7:0]. This holds whatever the bank and the armed state. A page read enables the non-volatile memory (nv_ce_n low, oe_n low). A page write asserts no chip enable and no we_n.
- R6: With bank 0xFF, window offsets 0x700-0x7FF give the same mem_addr as the slot page with the same low byte.
- R7: With buf_mode = 1 and the window armed, window reads select the non-volatile memory (nv_ce_n low) and window writes select the SRAM (ram_ce_n low).
- R8: With buf_mode = 0 and the window armed, window reads select the SRAM and window writes select the non-volatile memory.
- R9: bus_drive is high, and oe_n low, only in read cycles (rw = 1) of an active region. we_n is low only during phase 2 high of a write cycle to the armed window.
- R10: For window accesses, mem_addr = {bank, addr[10:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | Phase-2 bus clock; the state updates on its falling edge |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Bus address |
| din | input | 8 | Bus write data |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| dev_sel_n | input | 1 | Active-low strobe for the card's I/O range |
| io_sel_n | input | 1 | Active-low strobe for the card's slot page |
| io_strobe_n | input | 1 | Active-low strobe for the shared $C800-$CFFF window |
| buf_mode | input | 1 | Direction mode: 1 = SRAM written and memory read; 0 = the reverse |
| nv_ce_n | output | 1 | Non-volatile memory chip enable, active low |
| ram_ce_n | output | 1 | SRAM buffer chip enable, active low |
| oe_n | output | 1 | Shared output enable, active low |
| we_n | output | 1 | Shared write enable, active low |
| bus_drive | output | 1 | High when the card drives the data bus |
| mem_addr | output | 19 | Memory address |

## Verification
Enables, address and bus_drive settle within the same bus cycle as their inputs. we_n additionally waits for phase 2 to go high. The bench drives inputs 1 ns after the falling edge and samples 5 ns after the rising edge, so every combinational result is read while phase 2 is high and stable. Loads of the bank register and changes to the armed state show only in the following cycle. Each vector's expected value is therefore computed from the state that preceding vectors left behind. One directed check samples we_n in the low phase to show that it stays high there.

// File: rtl/slot_bank_decoder.sv
module slot_bank_decoder #(
  parameter int BANK_W = 8,
  parameter int OFF_W  = 11,
  parameter int PAGE_W = 8
) (
  input  logic                    phi2,
  input  logic                    rst_n,
  input  logic [15:0]             addr,
  input  logic [7:0]              din,
  input  logic                    rw,
  input  logic                    dev_sel_n,
  input  logic                    io_sel_n,
  input  logic                    io_strobe_n,
  input  logic                    buf_mode,
  output logic                    nv_ce_n,
  output logic                    ram_ce_n,
  output logic                    oe_n,
  output logic                    we_n,
  output logic                    bus_drive,
  output logic [BANK_W+OFF_W-1:0] mem_addr
);
  localparam int AW = BANK_W + OFF_W;

  logic [BANK_W-1:0] bank;
  logic              armed;

  wire io_wr    = !dev_sel_n && !rw;
  wire page_hit = !io_sel_n;
  wire win_hit  = !io_strobe_n && io_sel_n && armed;
  wire win_last = win_hit && !rw && (addr[OFF_W-1:0] == {OFF_W{1'b1}});
  wire active   = page_hit || win_hit;

  always_ff @(negedge phi2 or negedge rst_n) begin
    if (!rst_n) begin
      bank  <= '0;
      armed <= 1'b0;
    end else if (io_wr) begin
      bank  <= din[BANK_W-1:0];
      armed <= 1'b1;
    end else if (win_last) begin
      armed <= 1'b0;
    end
  end

  assign mem_addr  = page_hit ? {{(AW-PAGE_W){1'b1}}, addr[PAGE_W-1:0]}
                              : {bank, addr[OFF_W-1:0]};
  assign nv_ce_n   = !((page_hit && rw) || (win_hit && (rw == buf_mode)));
  assign ram_ce_n  = !(win_hit && (rw != buf_mode));
  assign oe_n      = !(active && rw);
  assign we_n      = !(win_hit && !rw && phi2);
  assign bus_drive = active && rw;

  p_load_r2: assert property (@(negedge phi2) disable iff (!rst_n)
    io_wr |=> (!io_sel_n || mem_addr[AW-1:OFF_W] == $past(din[BANK_W-1:0])));

  p_disarm_r4: assert property (@(negedge phi2) disable iff (!rst_n)
    (win_last && dev_sel_n) |=> (!io_sel_n || (nv_ce_n && ram_ce_n && oe_n)));

  p_page_top_r5: assert property (@(negedge phi2) disable iff (!rst_n)
    !io_sel_n |-> (mem_addr[AW-1:PAGE_W] == {(AW-PAGE_W){1'b1}} && ram_ce_n && we_n));

  p_one_chip_r7: assert property (@(negedge phi2) disable iff (!rst_n)
    !(!nv_ce_n && !ram_ce_n));

  p_drive_read_r9: assert property (@(negedge phi2) disable iff (!rst_n)
    bus_drive |-> (rw && !oe_n && we_n));
endmodule

// File: tb/slot_bank_decoder_bench.sv
module slot_bank_decoder_bench;
  localparam int PERIOD = 20;
  localparam int NV = 16;

  logic        phi2 = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  din = 8'h00;
  logic        rw = 1'b1, dev_sel_n = 1'b1, io_sel_n = 1'b1, io_strobe_n = 1'b1, buf_mode = 1'b0;
  logic        nv_ce_n, ram_ce_n, oe_n, we_n, bus_drive;
  logic [18:0] mem_addr;
  int          tests = 0, fails = 0;
  bit          done = 0;

  always #(PERIOD/2) phi2 = ~phi2;

  slot_bank_decoder u_slot_bank_decoder (
    .phi2(phi2), .rst_n(rst_n), .addr(addr), .din(din), .rw(rw),
    .dev_sel_n(dev_sel_n), .io_sel_n(io_sel_n), .io_strobe_n(io_strobe_n),
    .buf_mode(buf_mode), .nv_ce_n(nv_ce_n), .ram_ce_n(ram_ce_n), .oe_n(oe_n),
    .we_n(we_n), .bus_drive(bus_drive), .mem_addr(mem_addr));

  // {req, addr, rw, dev_sel_n, io_sel_n, io_strobe_n, buf_mode, din, nv_ce_n, ram_ce_n, oe_n, we_n, bus_drive, mem_addr}
  localparam logic [56:0] VEC [NV] = '{
    {4'd1,  16'hC812, 5'b1_1_1_0_1, 8'h00, 5'b1_1_1_1_0, 19'h00012}, // R1 disarmed window read
    {4'd2,  16'hC0F3, 5'b0_0_1_1_1, 8'h5A, 5'b1_1_1_1_0, 19'h000F3}, // R2 R3 load bank 5A
    {4'd7,  16'hC9AB, 5'b1_1_1_0_1, 8'h00, 5'b0_1_0_1_1, 19'h2D1AB}, // R7 read -> memory, R10 address
    {4'd7,  16'hC9AB, 5'b0_1_1_0_1, 8'h00, 5'b1_0_1_0_0, 19'h2D1AB}, // R7 write -> SRAM
    {4'd8,  16'hC9AB, 5'b1_1_1_0_0, 8'h00, 5'b1_0_0_1_1, 19'h2D1AB}, // R8 read -> SRAM
    {4'd8,  16'hC9AB, 5'b0_1_1_0_0, 8'h00, 5'b0_1_1_0_0, 19'h2D1AB}, // R8 write -> memory
    {4'd5,  16'hC742, 5'b1_1_0_1_1, 8'h00, 5'b0_1_0_1_1, 19'h7FF42}, // R5 page read
    {4'd5,  16'hC742, 5'b0_1_0_1_1, 8'h00, 5'b1_1_1_1_0, 19'h7FF42}, // R5 page write ignored
    {4'd2,  16'hC0F0, 5'b0_0_1_1_1, 8'hFF, 5'b1_1_1_1_0, 19'h2D0F0}, // R2 load bank FF
    {4'd6,  16'hCF42, 5'b1_1_1_0_1, 8'h00, 5'b0_1_0_1_1, 19'h7FF42}, // R6 alias of page
    {4'd4,  16'hCFFF, 5'b0_1_1_0_1, 8'h00, 5'b1_0_1_0_0, 19'h7FFFF}, // R4 last-byte write lands
    {4'd4,  16'hCFFF, 5'b1_1_1_0_1, 8'h00, 5'b1_1_1_1_0, 19'h7FFFF}, // R4 disarmed afterwards
    {4'd5,  16'hC7FF, 5'b1_1_0_1_1, 8'h00, 5'b0_1_0_1_1, 19'h7FFFF}, // R5 page while disarmed
    {4'd9,  16'hCFFF, 5'b0_1_1_0_1, 8'h00, 5'b1_1_1_1_0, 19'h7FFFF}, // R9 no we when disarmed
    {4'd3,  16'hC0F7, 5'b0_0_1_1_0, 8'h00, 5'b1_1_1_1_0, 19'h7F8F7}, // R3 rearm, bank 00
    {4'd10, 16'hC800, 5'b1_1_1_0_0, 8'h00, 5'b1_0_0_1_1, 19'h00000}  // R10 bank 00 offset 0
  };

  task automatic drive(input logic [15:0] a, input logic [4:0] ctl, input logic [7:0] d);
    @(negedge phi2); #1;
    addr = a; {rw, dev_sel_n, io_sel_n, io_strobe_n, buf_mode} = ctl; din = d;
    @(posedge phi2); #5;
  endtask

  task automatic check(input int req, input logic [23:0] exp);
    logic [23:0] act;
    act = {nv_ce_n, ram_ce_n, oe_n, we_n, bus_drive, mem_addr};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: {nv,ram,oe,we,drv,addr} actual %b_%05h expected %b_%05h",
               req, act[23:19], act[18:0], exp[23:19], exp[18:0]);
    end
  endtask

  initial begin
    #(PERIOD*2000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD*2 + 3); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][52:37], VEC[i][36:32], VEC[i][31:24]);
      check(int'(VEC[i][56:53]), VEC[i][23:0]);
    end
    // R9: we_n stays high in phase 1 of an armed window write (bank 00, armed)
    @(negedge phi2); #1;
    addr = 16'hC855; {rw, dev_sel_n, io_sel_n, io_strobe_n, buf_mode} = 5'b0_1_1_0_0; din = 8'h00;
    #4; check(9, {5'b0_1_1_1_0, 19'h00055});
    @(posedge phi2); #5; check(9, {5'b0_1_1_0_0, 19'h00055});
    // R1: reset clears bank and armed state
    drive(16'hC0F0, 5'b0_0_1_1_1, 8'h33);
    drive(16'hC812, 5'b1_1_1_0_1, 8'h00);
    check(7, {5'b0_1_0_1_1, 19'h19812});
    @(negedge phi2); #2; rst_n = 1'b0; #4; rst_n = 1'b1;
    @(posedge phi2); #5; check(1, {5'b1_1_1_1_0, 19'h00012});
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule